// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Controller

This block watches a set of general-purpose pins, grouped in banks of equal width, and turns selected signal edges into latched interrupt events. Each pin's raw input first crosses into the clock domain through a two-flop synchronizer. An edge detector then compares the synchronized value with its value one cycle earlier. A 2-bit trigger code per pin selects which edges count: none, rising only, falling only, or both.

Each detected edge sets a sticky status bit. Software clears a status bit by writing a 1 to it. A per-bank mask hides status bits from the bank's interrupt line. The mask is changed only through two write ports: one address sets mask bits and another clears them. Because of this, no read-modify-write is needed to mask or unmask a single pin. Each bank drives one interrupt output, which is high while any of its status bits is set and unmasked.

Level-sensitive triggering is not provided.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every status bit reads 0, every mask bit reads 1 (all pins masked), and every `irq_o` bit is 0.
- R2: A pin change is seen through a two-flop synchronizer. The resulting status bit is set at the third rising clock edge after the change and is still clear after the second edge.
- R3: Pin p's trigger code is `trig_i[2p+1:2p]`. Code 1 latches rising edges only, code 2 latches falling edges only, code 3 latches both, and code 0 latches nothing.
- R4: The status of bank b is read at byte address 0x80+4b. Writing there clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to 0xA0+4b sets the mask bits of bank b that are written as 1 and leaves the others unchanged. This address reads back the mask.
- R6: A write to 0xC0+4b clears the mask bits of bank b that are written as 1 and leaves the others unchanged. This address also reads back the mask.
- R7: `irq_o[b]` is high exactly while bank b has a status bit that is set and not masked. Masked pins still latch status.
- R8: If an edge is latched on a bit in the same cycle that a write-1-to-clear hits that bit, the bit stays set.
- R9: `rdata_o` is combinational from `addr_i`. Addresses that match no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_BANKS*PINS_PER_BANK | Asynchronous pin inputs, bank-major |
| trig_i | input | 2*NUM_BANKS*PINS_PER_BANK | Per-pin trigger codes, 2 bits per pin |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | PINS_PER_BANK | Write data, one bit per pin of the bank |
| rdata_o | output | PINS_PER_BANK | Read data for `addr_i` |
| irq_o | output | NUM_BANKS | Per-bank interrupt line |

## Verification
The assertions inside each bank check the following on every cycle:
- write-1-to-clear removes exactly the written bits unless an edge arrives;
- a latched edge always leaves its bit set, even against a clear;
- the mask-set and mask-clear writes move the addressed bits in the right direction;
- no status bit appears without a detected edge.

Only the bench scenarios can show the rest:
- the end-to-end latency through the synchronizer;
- the meaning of each trigger code against real pin waveforms;
- the address decode and the read-back values;
- the interrupt line's response to mixed mask and status patterns.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  localparam int unsigned STAT_BASE = 32'h80;
  localparam int unsigned MSET_BASE = 32'hA0;
  localparam int unsigned MCLR_BASE = 32'hC0;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   sync_i,
  input  logic [2*WIDTH-1:0] trig_i,
  output logic [WIDTH-1:0]   evt_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    trig_e trig;
    logic  rise, fall;
    assign trig = trig_e'(trig_i[2*i +: 2]);
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];
    always_comb begin
      case (trig)
        TRIG_RISE: evt_o[i] = rise;
        TRIG_FALL: evt_o[i] = fall;
        TRIG_BOTH: evt_o[i] = rise | fall;
        default:   evt_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             wr_stat_i,
  input  logic             wr_mset_i,
  input  logic             wr_mclr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] status_q, mask_q, clr_bits;

  assign clr_bits = wr_stat_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      // a new edge takes priority over a clear of the same bit
      status_q <= (status_q & ~clr_bits) | evt_i;
      if (wr_mset_i)      mask_q <= mask_q | wdata_i;
      else if (wr_mclr_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i |=> ((status_q & $past(wdata_i & ~evt_i)) == '0));

  a_r8_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  a_r5_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  a_r6_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mclr_i && !wr_mset_i) |=> ((mask_q & $past(wdata_i)) == '0));

  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~$past(status_q) & ~$past(evt_i)) == '0);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned PINS_PER_BANK = 8,
  parameter int unsigned ADDR_W        = 8,
  localparam int unsigned NUM_PINS     = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [2*NUM_PINS-1:0] trig_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [PINS_PER_BANK-1:0] wdata_i,
  output logic [PINS_PER_BANK-1:0] rdata_o,
  output logic [NUM_BANKS-1:0]  irq_o
);
  localparam int unsigned PW = PINS_PER_BANK;

  function automatic logic [ADDR_W-1:0] reg_addr(int unsigned base, int unsigned bank);
    return ADDR_W'(base + 4 * bank);
  endfunction

  logic [NUM_PINS-1:0] sync_w, evt_w;
  logic [PW-1:0]       status_w [NUM_BANKS];
  logic [PW-1:0]       mask_w   [NUM_BANKS];

  gpio_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_w)
  );

  gpio_irq_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sync_i(sync_w), .trig_i(trig_i), .evt_o(evt_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_stat, wr_mset, wr_mclr;
    assign wr_stat = we_i && (addr_i == reg_addr(STAT_BASE, b));
    assign wr_mset = we_i && (addr_i == reg_addr(MSET_BASE, b));
    assign wr_mclr = we_i && (addr_i == reg_addr(MCLR_BASE, b));

    gpio_irq_bank #(.WIDTH(PW)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_w[b*PW +: PW]),
      .wr_stat_i(wr_stat),
      .wr_mset_i(wr_mset),
      .wr_mclr_i(wr_mclr),
      .wdata_i  (wdata_i),
      .status_o (status_w[b]),
      .mask_o   (mask_w[b]),
      .irq_o    (irq_o[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == reg_addr(STAT_BASE, b)) rdata_o = status_w[b];
      if (addr_i == reg_addr(MSET_BASE, b) || addr_i == reg_addr(MCLR_BASE, b))
        rdata_o = mask_w[b];
    end
  end
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int NB = 2;
  localparam int PW = 8;
  localparam int NP = NB * PW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pins = '0;
  logic [2*NP-1:0] trig = '0;
  logic            we = 1'b0;
  logic [7:0]      addr = '0;
  logic [PW-1:0]   wdata = '0;
  logic [PW-1:0]   rdata;
  logic [NB-1:0]   irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [PW-1:0] exp_stat [NB];
  logic [PW-1:0] exp_mask [NB];

  always #5 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .trig_i(trig), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] f_evt(logic [NP-1:0] o, logic [NP-1:0] n, logic [2*NP-1:0] t);
    logic [NP-1:0] e = '0;
    for (int i = 0; i < NP; i++) begin
      case (t[2*i +: 2])
        2'd1: e[i] = n[i] & ~o[i];
        2'd2: e[i] = ~n[i] & o[i];
        2'd3: e[i] = n[i] ^ o[i];
        default: e[i] = 1'b0;
      endcase
    end
    return e;
  endfunction

  task automatic rd(input logic [7:0] a, output logic [PW-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [PW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (a == 8'(8'h80 + 4*b)) exp_stat[b] &= ~d;
      if (a == 8'(8'hA0 + 4*b)) exp_mask[b] |= d;
      if (a == 8'(8'hC0 + 4*b)) exp_mask[b] &= ~d;
    end
  endtask

  task automatic drive_pins(input logic [NP-1:0] n);
    logic [NP-1:0] e;
    @(negedge clk);
    e = f_evt(pins, n, trig);
    pins = n;
    repeat (4) @(negedge clk);
    for (int b = 0; b < NB; b++) exp_stat[b] |= e[b*PW +: PW];
  endtask

  task automatic check_all(input string tag);
    logic [PW-1:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(8'(8'h80 + 4*b), d);
      chk({tag, " status"}, d, exp_stat[b]);
      rd(8'(8'hA0 + 4*b), d);
      chk({tag, " mask"}, d, exp_mask[b]);
      chk({tag, " R7 irq"}, irq[b], |(exp_stat[b] & ~exp_mask[b]));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [PW-1:0] d;
    void'($urandom(32'd4711));
    for (int b = 0; b < NB; b++) begin
      exp_stat[b] = '0;
      exp_mask[b] = '1;
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 latency on pin 0 with rising trigger; unmask bank 0 first (R6)
    trig = '0;
    trig[1:0] = 2'd1;
    wr(8'hC0, 8'hFF);
    check_all("R6 mask clear");
    rd(8'h80, d);
    @(negedge clk);
    pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1 chk("R2 not yet set", rdata[0], 1'b0);
    @(negedge clk);
    #1 chk("R2 set on third edge", rdata[0], 1'b1);
    chk("R7 irq up", irq[0], 1'b1);
    exp_stat[0][0] = 1'b1;
    repeat (2) @(negedge clk);

    // R3 codes per pin of bank 0: p1 fall, p2 both, p3 off
    trig[3:2] = 2'd2;
    trig[5:4] = 2'd3;
    trig[7:6] = 2'd0;
    drive_pins(pins | 16'h000E);
    check_all("R3 rise on fall/both/off");
    drive_pins(pins & ~16'h000F);
    check_all("R3 fall on rise/fall/both/off");

    // R4 write-1-to-clear, zeros leave bits alone
    wr(8'h80, 8'h02);
    check_all("R4 w1c partial");

    // R8 edge coincides with clear: pin 2 set already; make new edge
    wr(8'h80, 8'h00);
    check_all("R4 write zero");
    @(negedge clk);
    pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 8'h80; wdata = 8'h04;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    #1;
    check_all("R8 edge wins");

    // R5 mask set hides irq but status still latches
    wr(8'hA0, 8'hFF);
    check_all("R5 mask set");
    drive_pins(pins & ~16'h0004);
    check_all("R7 masked latch");

    // R9 unmapped address reads zero, mask-clear address reads mask
    rd(8'h84 + 8'h10, d);
    chk("R9 unmapped", d, 8'h00);
    rd(8'hC4, d);
    chk("R9 mclr readback", d, exp_mask[1]);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 5);
      int b = $urandom_range(0, NB - 1);
      case (op)
        0, 1: drive_pins(NP'($urandom));
        2: wr(8'(8'h80 + 4*b), PW'($urandom));
        3: wr(8'(8'hA0 + 4*b), PW'($urandom));
        4: wr(8'(8'hC0 + 4*b), PW'($urandom));
        default: begin
          @(negedge clk);
          trig = (2*NP)'({$urandom, $urandom});
        end
      endcase
      check_all("R3 R4 R5 R6 random");
    end

    done = 1;
    finish_run();
  end
endmodule